// File: doc/BRIEF.md
# Mounting-Height Compensation Datapath for a Differential Hall Current Sensor

This block sits after the converters of a coreless Hall current sensor whose current trace lies on the board under the package. Two signed sample streams arrive under a single valid strobe. One carries the difference of the vertical field between the two sides of the trace. The other carries the difference of the lateral field between the centre and the sides. How far the die sits above the trace changes both signals. The lateral one changes roughly twice as fast, so a weighted difference of the two cancels the height term. The block produces that weighted difference as a current value that stays put when the mounting height varies.

Two ways of running are offered. In live mode, every sample is the vertical sample scaled by a layout-dependent weight, minus the lateral sample. Height drift after assembly is therefore tracked for as long as the part runs. In stored-ratio mode, a correction factor is captured once: after soldering, a calibration request is issued while some current flows. The datapath divides the live result by the vertical sample and keeps the quotient. From then on it scales only the vertical sample by that factor and drops the lateral channel enable, so the auxiliary sensing can be powered off. Two registers hold the weight and the captured factor; they stand in for non-volatile storage.

Top module: `hall_comp_top`

## Requirements
- R1: After reset, out_valid, out_data, busy, ratio_valid and cal_err are 0, lat_en is 1, and the weight holds its default of 9462 (2.31 in unsigned Q4.12).
- R2: When ratio_valid is 0 or mode_ratio is 0, a sample accepted at a clock edge yields, after that edge, out_valid=1 and out_data = floor(vert_in*m/4096) - lat_in. Without an accepted sample, out_valid is 0 after the edge.
- R3: out_data saturates to 32767 or -32768 when the exact result lies outside the signed 16-bit range; it never wraps.
- R4: coef_we=1 at an edge loads coef_in into the weight m (unsigned Q4.12), and m applies from the next edge on.
- R5: A sample accepted with cal_req=1 that passes the R10 test starts a calibration. busy is 1 for exactly 34 cycles. Then ratio_valid becomes 1, and the stored ratio r (unsigned Q4.12) becomes min(65535, floor(|c|*4096/|vert_in|)), where c is the R2 value before saturation. ratio_valid stays 1 until reset.
- R6: A sample presented while busy is 1 is dropped: no out_valid, no calibration start.
- R7: With mode_ratio=1 and ratio_valid=1, out_data = saturate(floor(vert_in*r/4096)), and lat_in has no influence on it.
- R8: lat_en is 0 from the edge after one at which mode_ratio=1 and ratio_valid=1 were both seen; otherwise it is 1.
- R9: With mode_ratio=1 before any successful calibration, outputs follow R2, and lat_en stays 1.
- R10: A calibration attempt with |vert_in| < 64, or with c and vert_in of strictly opposite sign, sets cal_err after that edge. It does not start busy and leaves ratio_valid and r unchanged. cal_err is cleared when a calibration completes.
- R11: Only a calibration changes r; later writes of m do not change stored-ratio outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe shared by both channels |
| vert_in | input | 16 | Signed vertical-field difference sample |
| lat_in | input | 16 | Signed lateral-field difference sample |
| cal_req | input | 1 | Calibration request, taken with an accepted sample |
| mode_ratio | input | 1 | 1 selects stored-ratio operation, 0 selects live compensation |
| coef_we | input | 1 | Load strobe for the weight |
| coef_in | input | 16 | New weight, unsigned Q4.12 |
| out_valid | output | 1 | Result strobe, one cycle after the accepted sample |
| out_data | output | 16 | Signed, saturated compensated current value |
| lat_en | output | 1 | Enable for the lateral-field channel |
| busy | output | 1 | Ratio division in progress |
| ratio_valid | output | 1 | A ratio has been captured |
| cal_err | output | 1 | Last calibration attempt was rejected |

## Verification
Live compensation is driven with mixed-sign pairs, a zero vertical sample and samples near full scale. These separate the floor rounding of the Q4.12 product and the subtraction order from the two saturation limits. Calibration is tried with a small vertical sample, a zero one and an opposite-sign result, each of which must be rejected. It is also tried with a regular pair, and with a pair whose quotient exceeds the ratio range, so that the clamping of r can be told apart from a correct quotient. In stored-ratio mode, large lateral samples are paired with fixed vertical ones, and the weight is rewritten. This shows that only r and the vertical sample set the output. Samples and a further request sent during the division must leave no trace.

// File: rtl/hall_comp_pkg.sv
package hall_comp_pkg;

  // Path that forms the output for the current sample
  typedef enum logic {
    SEL_LIVE   = 1'b0,
    SEL_STORED = 1'b1
  } sel_e;

  localparam int unsigned DEF_DW   = 16;
  localparam int unsigned DEF_CW   = 16;
  localparam int unsigned DEF_FRAC = 12;

endpackage

// File: rtl/hall_comp_scale.sv
// Weighted sample minus optional subtrahend, full precision, floor rounding.
module hall_comp_scale #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int FRAC   = 12,
  parameter int COMP_W = 22
) (
  input  logic signed [DW-1:0]     x,
  input  logic        [CW-1:0]     w,
  input  logic signed [DW-1:0]     y,
  input  logic                     sub_en,
  output logic signed [COMP_W-1:0] full
);
  localparam int PROD_W = DW + CW + 1;

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] w_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [COMP_W-1:0] y_ext;
  logic signed [COMP_W-1:0] scaled;

  assign x_ext  = {{(PROD_W-DW){x[DW-1]}}, x};
  assign w_ext  = {{(PROD_W-CW){1'b0}}, w};
  assign prod   = x_ext * w_ext;
  assign scaled = COMP_W'(prod >>> FRAC);
  assign y_ext  = {{(COMP_W-DW){y[DW-1]}}, y};
  assign full   = sub_en ? (scaled - y_ext) : scaled;

endmodule

// File: rtl/hall_comp_sat.sv
// Clamp a wide signed value into a narrower signed range.
module hall_comp_sat #(
  parameter int IW = 22,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] d,
  output logic signed [OW-1:0] q
);
  logic [IW-OW:0] top_bits;

  assign top_bits = d[IW-1:OW-1];

  always_comb begin
    if (top_bits == '0 || top_bits == '1) begin
      q = d[OW-1:0];
    end else if (d[IW-1]) begin
      q = {1'b1, {(OW-1){1'b0}}};
    end else begin
      q = {1'b0, {(OW-1){1'b1}}};
    end
  end

endmodule

// File: rtl/hall_comp_div.sv
// Restoring divider, one quotient bit per clock, NW steps per division.
module hall_comp_div #(
  parameter int NW   = 34,
  parameter int DENW = 16,
  parameter int QW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NW-1:0]   num,
  input  logic [DENW-1:0] den,
  output logic            busy,
  output logic            fin,
  output logic [QW-1:0]   quo
);
  localparam int CNT_W = $clog2(NW);

  logic [NW-1:0]    n_q;
  logic [NW-1:0]    q_q;
  logic [NW-1:0]    q_nx;
  logic [DENW-1:0]  rem_q;
  logic [DENW-1:0]  rem_nx;
  logic [DENW:0]    rem_sh;
  logic [DENW-1:0]  d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             take;

  always_comb begin
    rem_sh = {rem_q, n_q[NW-1]};
    take   = rem_sh >= {1'b0, d_q};
    rem_nx = take ? DENW'(rem_sh - {1'b0, d_q}) : rem_sh[DENW-1:0];
    q_nx   = {q_q[NW-2:0], take};
  end

  assign fin  = busy_q && (cnt_q == CNT_W'(NW-1));
  assign quo  = (|q_nx[NW-1:QW]) ? '1 : q_nx[QW-1:0];
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q    <= '0;
      q_q    <= '0;
      rem_q  <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      n_q   <= n_q << 1;
      rem_q <= rem_nx;
      q_q   <= q_nx;
      cnt_q <= cnt_q + CNT_W'(1);
      if (fin) begin
        busy_q <= 1'b0;
      end
    end else if (start) begin
      n_q    <= num;
      d_q    <= den;
      rem_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end
  end

endmodule

// File: rtl/hall_comp_top.sv
module hall_comp_top
  import hall_comp_pkg::*;
#(
  parameter int DW      = DEF_DW,
  parameter int CW      = DEF_CW,
  parameter int FRAC    = DEF_FRAC,
  parameter int MIN_MAG = 64,
  parameter int M_RESET = 9462
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] vert_in,
  input  logic signed [DW-1:0] lat_in,
  input  logic                 cal_req,
  input  logic                 mode_ratio,
  input  logic                 coef_we,
  input  logic [CW-1:0]        coef_in,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic                 lat_en,
  output logic                 busy,
  output logic                 ratio_valid,
  output logic                 cal_err
);
  localparam int PROD_W = DW + CW + 1;
  localparam int COMP_W = PROD_W - FRAC + 1;
  localparam int NUM_W  = COMP_W + FRAC;

  logic [CW-1:0]            coef_q;
  logic [CW-1:0]            ratio_q;
  logic                     rv_q;
  logic                     err_q;
  logic signed [COMP_W-1:0] live_full;
  logic signed [COMP_W-1:0] stored_full;
  logic signed [DW-1:0]     live_sat;
  logic signed [DW-1:0]     stored_sat;
  logic [DW-1:0]            v_mag;
  logic [COMP_W-1:0]        c_mag;
  logic [NUM_W-1:0]         div_num;
  logic [CW-1:0]            div_quo;
  logic                     div_busy;
  logic                     div_fin;
  logic                     accept;
  logic                     cal_try;
  logic                     cal_bad;
  logic                     sign_clash;
  logic                     cal_go;
  sel_e                     sel;

  assign sel    = (mode_ratio && rv_q) ? SEL_STORED : SEL_LIVE;
  assign accept = in_valid && !div_busy;

  hall_comp_scale #(.DW(DW), .CW(CW), .FRAC(FRAC), .COMP_W(COMP_W)) u_live (
    .x(vert_in), .w(coef_q), .y(lat_in), .sub_en(1'b1), .full(live_full)
  );

  hall_comp_scale #(.DW(DW), .CW(CW), .FRAC(FRAC), .COMP_W(COMP_W)) u_stored (
    .x(vert_in), .w(ratio_q), .y(lat_in), .sub_en(1'b0), .full(stored_full)
  );

  hall_comp_sat #(.IW(COMP_W), .OW(DW)) u_sat_live (
    .d(live_full), .q(live_sat)
  );

  hall_comp_sat #(.IW(COMP_W), .OW(DW)) u_sat_stored (
    .d(stored_full), .q(stored_sat)
  );

  // Calibration qualification on the live result
  assign v_mag      = vert_in[DW-1] ? (~vert_in + DW'(1)) : vert_in;
  assign c_mag      = live_full[COMP_W-1] ? (~live_full + COMP_W'(1)) : live_full;
  assign sign_clash = (live_full[COMP_W-1] && !vert_in[DW-1]) ||
                      (!live_full[COMP_W-1] && (|live_full) && vert_in[DW-1]);
  assign cal_try    = accept && cal_req;
  assign cal_bad    = (v_mag < DW'(MIN_MAG)) || sign_clash;
  assign cal_go     = cal_try && !cal_bad;
  assign div_num    = {c_mag, {FRAC{1'b0}}};

  hall_comp_div #(.NW(NUM_W), .DENW(DW), .QW(CW)) u_div (
    .clk(clk), .rst(rst), .start(cal_go), .num(div_num), .den(v_mag),
    .busy(div_busy), .fin(div_fin), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      lat_en    <= 1'b1;
      coef_q    <= CW'(M_RESET);
      ratio_q   <= '0;
      rv_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_data <= (sel == SEL_STORED) ? stored_sat : live_sat;
      end
      lat_en <= (sel == SEL_LIVE);
      if (coef_we) begin
        coef_q <= coef_in;
      end
      if (cal_try && cal_bad) begin
        err_q <= 1'b1;
      end
      if (div_fin) begin
        ratio_q <= div_quo;
        rv_q    <= 1'b1;
        err_q   <= 1'b0;
      end
    end
  end

  assign busy        = div_busy;
  assign ratio_valid = rv_q;
  assign cal_err     = err_q;

endmodule

// File: rtl/hall_comp_chk.sv
module hall_comp_chk #(
  parameter int NW = 34
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic cal_req,
  input logic mode_ratio,
  input logic out_valid,
  input logic lat_en,
  input logic busy,
  input logic ratio_valid,
  input logic cal_err
);
  localparam int RW = $clog2(NW + 2);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      run <= '0;
    end else begin
      run <= run + RW'(1);
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> out_valid);

  assert_drop_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> !out_valid);

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(in_valid && cal_req));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == RW'(NW)));

  assert_ratio_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ratio_valid |=> ratio_valid);

  assert_chan_off_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_ratio && ratio_valid) |=> !lat_en);

  assert_fallback_R9: assert property (@(posedge clk) disable iff (rst)
    !ratio_valid |=> lat_en);

  assert_reject_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_err) |-> !busy);

endmodule

bind hall_comp_top hall_comp_chk #(.NW(NUM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cal_req(cal_req),
  .mode_ratio(mode_ratio), .out_valid(out_valid), .lat_en(lat_en),
  .busy(busy), .ratio_valid(ratio_valid), .cal_err(cal_err)
);

// File: tb/tb_hall_comp_top.sv
`timescale 1ns/1ps
module tb_hall_comp_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] vert_in = '0;
  logic signed [15:0] lat_in = '0;
  logic               cal_req = 1'b0;
  logic               mode_ratio = 1'b0;
  logic               coef_we = 1'b0;
  logic [15:0]        coef_in = '0;
  logic               out_valid;
  logic signed [15:0] out_data;
  logic               lat_en;
  logic               busy;
  logic               ratio_valid;
  logic               cal_err;

  hall_comp_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vert_in(vert_in), .lat_in(lat_in),
    .cal_req(cal_req), .mode_ratio(mode_ratio), .coef_we(coef_we), .coef_in(coef_in),
    .out_valid(out_valid), .out_data(out_data), .lat_en(lat_en), .busy(busy),
    .ratio_valid(ratio_valid), .cal_err(cal_err)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "";

  // Reference state
  int    m_m, m_r, m_pend, m_cnt, m_od;
  bit    m_rv, m_busy, m_err, m_ov, m_lat;
  string d_tag = "R2";
  string v_tag = "R2";

  function automatic int sat16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint got, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin : model
    longint c, p, cm, vm, q;
    bit eff;
    if (rst) begin
      m_m = 9462; m_r = 0; m_pend = 0; m_cnt = 0; m_od = 0;
      m_rv = 0; m_busy = 0; m_err = 0; m_ov = 0; m_lat = 1;
    end else begin
      eff   = mode_ratio && m_rv;
      v_tag = (in_valid && m_busy) ? "R6" : "R2";
      m_ov  = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 34) begin
          m_busy = 0; m_r = m_pend; m_rv = 1; m_err = 0;
        end
      end else if (in_valid) begin
        c = ((longint'(vert_in) * m_m) >>> 12) - longint'(lat_in);
        p = (longint'(vert_in) * m_r) >>> 12;
        m_ov = 1;
        if (eff) begin
          m_od = sat16(p); d_tag = "R7";
        end else begin
          m_od = sat16(c);
          d_tag = mode_ratio ? "R9" : ((c > 32767 || c < -32768) ? "R3" : "R2");
        end
        if (cal_req) begin
          vm = (vert_in < 0) ? -longint'(vert_in) : longint'(vert_in);
          if (vm < 64 || (c > 0 && vert_in < 0) || (c < 0 && vert_in > 0)) begin
            m_err = 1;
          end else begin
            cm = (c < 0) ? -c : c;
            q  = (cm * 4096) / vm;
            if (q > 65535) q = 65535;
            m_pend = int'(q); m_busy = 1; m_cnt = 0;
          end
        end
      end
      m_lat = !eff;
      if (coef_we) m_m = int'(coef_in);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid === m_ov, v_tag, "out_valid", out_valid, m_ov);
      if (m_ov) chk(out_data === 16'(m_od), {phase, " ", d_tag}, "out_data", out_data, m_od);
      chk(lat_en === m_lat, "R8", "lat_en", lat_en, m_lat);
      chk(busy === m_busy, "R5", "busy", busy, m_busy);
      chk(ratio_valid === m_rv, "R5", "ratio_valid", ratio_valid, m_rv);
      chk(cal_err === m_err, "R10", "cal_err", cal_err, m_err);
    end
  end

  task automatic drive(int v, int l, bit cal);
    in_valid = 1'b1; vert_in = 16'(v); lat_in = 16'(l); cal_req = cal;
    @(negedge clk);
    in_valid = 1'b0; cal_req = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; cal_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic coefw(int v);
    coef_we = 1'b1; coef_in = 16'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: values held under reset
    chk(out_valid === 1'b0, "R1", "out_valid", out_valid, 0);
    chk(out_data === 16'sd0, "R1", "out_data", out_data, 0);
    chk(lat_en === 1'b1, "R1", "lat_en", lat_en, 1);
    chk(busy === 1'b0, "R1", "busy", busy, 0);
    chk(ratio_valid === 1'b0, "R1", "ratio_valid", ratio_valid, 0);
    chk(cal_err === 1'b0, "R1", "cal_err", cal_err, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: live compensation, back-to-back and with gaps
    drive(1000, 500, 0); drive(-1000, 200, 0); drive(0, -300, 0);
    idle(2);
    drive(4096, 0, 0); drive(-7, 3, 0);
    idle(1);
    // R3: both clamp limits
    drive(20000, -30000, 0); drive(-32768, 32767, 0); drive(32767, -32768, 0);
    idle(1);

    // R9: stored mode requested before any ratio exists
    mode_ratio = 1'b1;
    drive(1500, 100, 0); drive(-800, -50, 0);
    idle(2);
    mode_ratio = 1'b0;

    // R10: rejected calibrations
    drive(10, 0, 1); idle(2);
    drive(1000, 5000, 1); idle(2);
    drive(0, 0, 1); idle(2);

    // R5 / R6: regular calibration, extra samples during division
    drive(2000, 2000, 1); drive(3000, 100, 1); drive(1, 1, 0);
    idle(40);

    // R7 / R8: stored-ratio operation
    mode_ratio = 1'b1;
    idle(2);
    drive(2000, 0, 0); drive(2000, -20000, 0); drive(-4000, 12345, 0); drive(30000, 0, 0);
    idle(2);

    // R11: rewriting the weight leaves stored outputs alone
    phase = "R11";
    coefw(4096);
    drive(2000, 7, 0); drive(-1234, 0, 0);
    idle(2);

    // R4: new weight used in live mode
    phase = "R4";
    mode_ratio = 1'b0;
    idle(2);
    drive(2000, 100, 0); drive(-3000, -3000, 0);
    phase = "";
    coefw(9462);
    idle(1);

    // R5: quotient beyond ratio range clamps
    drive(64, -30000, 1);
    idle(40);
    mode_ratio = 1'b1;
    idle(1);
    drive(100, 0, 0); drive(-100, 0, 0); drive(1000, 0, 0);
    idle(3);
    report();
  end

endmodule